// File: doc/BRIEF.md
# Memory Port with Address/Buffer Registers and Wait Stall

This block sits between a microcoded datapath and a slow external memory. The datapath reaches memory only through two registers. The address register (MAR) holds the location to access. The buffer register (MBR) holds the data to write or receives the data read. Each microcode step carries a two-bit memory field that selects no operation, read, write or wait. A read or write is launched at the end of the step that names it. It uses the MAR and MBR values that are in place at the end of that step, so the address can be loaded from the bus in the same step that starts the read.

Only one operation may be outstanding at a time. The external side is a level request held until a one-cycle acknowledge, and the latency is free to vary. The datapath never polls for completion. It issues a wait command, and the block holds the microsequencer for as long as the earlier operation is still open. Read data is captured into MBR on the acknowledge, so the first step after a wait can use it. A read or write that arrives while the port is busy is dropped and raises an error flag.

Top module: `mxi_memport`

## Requirements
- R1: After reset, ext_req, step_hold and op_err are low, and mar_q and mbr_q are zero.
- R2: With mar_load high, mar_q takes bus_val (low AW bits) at the clock edge. With mbr_load high, mbr_q takes bus_val at the edge, unless R10 applies.
- R3: mem_op = 2'b01 (read) with no operation open raises ext_req with ext_we low from the next cycle. ext_addr is the MAR value after that edge, including a load made in the same step.
- R4: mem_op = 2'b10 (write) with no operation open raises ext_req with ext_we high from the next cycle. ext_addr and ext_wdata are the MAR and MBR values after that edge, including loads made in the same step.
- R5: While a request is open and ext_ack is low, ext_req, ext_we, ext_addr and ext_wdata hold their values. ext_req falls in the cycle after ext_ack, unless a new operation is launched at that edge.
- R6: mem_op = 2'b11 (wait) drives step_hold high while an operation is open and ext_ack is low. step_hold is low in the cycle in which ext_ack is high.
- R7: On the ext_ack of a read, mbr_q takes ext_rdata at that edge. On the ext_ack of a write, mbr_q is left unchanged.
- R8: A wait with no operation open leaves step_hold low.
- R9: A read or write issued while an operation is open and ext_ack is low is ignored: ext_addr, ext_we and ext_wdata keep the open request. op_err is set at that edge and, with the default STICKY_ERR = 1, stays set until reset.
- R10: When a read completes in the same cycle that mbr_load is high, mbr_q takes ext_rdata and not bus_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_val | input | DW | Internal datapath bus value |
| mar_load | input | 1 | Load MAR from the bus this step |
| mbr_load | input | 1 | Load MBR from the bus this step |
| mem_op | input | 2 | Memory field: 00 none, 01 read, 10 write, 11 wait |
| mar_q | output | AW | Address register contents |
| mbr_q | output | DW | Buffer register contents |
| step_hold | output | 1 | Stall for the microsequencer |
| op_err | output | 1 | A read or write was issued while busy |
| ext_req | output | 1 | Memory request, held until acknowledged |
| ext_we | output | 1 | 1 = write, 0 = read |
| ext_addr | output | AW | Memory address |
| ext_wdata | output | DW | Write data |
| ext_rdata | input | DW | Read data, valid with ext_ack |
| ext_ack | input | 1 | One-cycle completion strobe |

## Verification
The bench loads MAR and issues a read in the same step, and loads MBR and issues a write in the same step. A design that launched from the old register values would put a stale address or stale data on the port. It also checks that step_hold drops in the acknowledge cycle itself. A design that released one cycle late would waste a step, and one that released early would let the datapath read MBR before the data arrives. A command issued while busy must leave the open request intact and set the flag. A read acknowledge that coincides with a bus load of MBR must leave the memory data in MBR, because giving the bus priority would lose the read.

// File: rtl/mxi_pkg.sv
package mxi_pkg;
   typedef enum logic [1:0] {
      MOP_NONE  = 2'b00,
      MOP_READ  = 2'b01,
      MOP_WRITE = 2'b10,
      MOP_WAIT  = 2'b11
   } mop_e;
endpackage

// File: rtl/mxi_regs.sv
module mxi_regs #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] bus_val,
   input  logic          mar_load,
   input  logic          mbr_load,
   input  logic          rd_done,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] mar_q,
   output logic [DW-1:0] mbr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mar_q <= '0;
         mbr_q <= '0;
      end else begin
         if (mar_load) mar_q <= bus_val[AW-1:0];
         if (rd_done)       mbr_q <= rdata;
         else if (mbr_load) mbr_q <= bus_val;
      end
   end

   // R2
   mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mar_load |=> mar_q == $past(bus_val[AW-1:0]));
   // R7
   rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> mbr_q == $past(rdata));
endmodule

// File: rtl/mxi_ctl.sv
module mxi_ctl
   import mxi_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter bit STICKY_ERR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  mop_e          op,
   input  logic          mar_load,
   input  logic          mbr_load,
   input  logic [DW-1:0] bus_val,
   input  logic [AW-1:0] mar_q,
   input  logic [DW-1:0] mbr_q,
   input  logic          ack,
   output logic          busy,
   output logic          we,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] wdata,
   output logic          rd_done,
   output logic          stall,
   output logic          err
);
   logic is_rw, free_slot, launch, rejected;

   assign is_rw     = (op == MOP_READ) || (op == MOP_WRITE);
   assign free_slot = !busy || ack;
   assign launch    = is_rw && free_slot;
   assign rejected  = is_rw && !free_slot;
   assign rd_done   = busy && ack && !we;
   assign stall     = (op == MOP_WAIT) && busy && !ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         we    <= 1'b0;
         addr  <= '0;
         wdata <= '0;
      end else if (launch) begin
         busy  <= 1'b1;
         we    <= (op == MOP_WRITE);
         addr  <= mar_load ? bus_val[AW-1:0] : mar_q;
         wdata <= mbr_load ? bus_val : mbr_q;
      end else if (ack) begin
         busy  <= 1'b0;
      end
   end

   generate
      if (STICKY_ERR) begin : g_sticky
         always_ff @(posedge clk) begin
            if (!rst_n) err <= 1'b0;
            else        err <= err | rejected;
         end
         // R9
         err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err |=> err);
      end else begin : g_pulse
         always_ff @(posedge clk) begin
            if (!rst_n) err <= 1'b0;
            else        err <= rejected;
         end
      end
   endgenerate

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ack) |=> busy && $stable(addr) && $stable(we) && $stable(wdata));
   // R6
   hold_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> busy && !ack);
   // R8
   no_idle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !stall);
endmodule

// File: rtl/mxi_memport.sv
module mxi_memport
   import mxi_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter bit STICKY_ERR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] bus_val,
   input  logic          mar_load,
   input  logic          mbr_load,
   input  logic [1:0]    mem_op,
   output logic [AW-1:0] mar_q,
   output logic [DW-1:0] mbr_q,
   output logic          step_hold,
   output logic          op_err,
   output logic          ext_req,
   output logic          ext_we,
   output logic [AW-1:0] ext_addr,
   output logic [DW-1:0] ext_wdata,
   input  logic [DW-1:0] ext_rdata,
   input  logic          ext_ack
);
   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("mxi_memport: AW and DW must be at least 1");
      end
      if (AW > DW) begin : g_bad_aw
         $error("mxi_memport: AW must not exceed DW");
      end
   endgenerate

   mop_e op;
   logic rd_done;

   assign op = mop_e'(mem_op);

   mxi_regs #(.AW(AW), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_val  (bus_val),
      .mar_load (mar_load),
      .mbr_load (mbr_load),
      .rd_done  (rd_done),
      .rdata    (ext_rdata),
      .mar_q    (mar_q),
      .mbr_q    (mbr_q)
   );

   mxi_ctl #(.AW(AW), .DW(DW), .STICKY_ERR(STICKY_ERR)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .mar_load (mar_load),
      .mbr_load (mbr_load),
      .bus_val  (bus_val),
      .mar_q    (mar_q),
      .mbr_q    (mbr_q),
      .ack      (ext_ack),
      .busy     (ext_req),
      .we       (ext_we),
      .addr     (ext_addr),
      .wdata    (ext_wdata),
      .rd_done  (rd_done),
      .stall    (step_hold),
      .err      (op_err)
   );
endmodule

// File: tb/mxi_memport_test.sv
`timescale 1ns/1ps
module mxi_memport_test;
   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [DW-1:0] bus_val;
   logic          mar_load, mbr_load;
   logic [1:0]    mem_op;
   logic [AW-1:0] mar_q;
   logic [DW-1:0] mbr_q;
   logic          step_hold, op_err;
   logic          ext_req, ext_we;
   logic [AW-1:0] ext_addr;
   logic [DW-1:0] ext_wdata;
   logic [DW-1:0] ext_rdata;
   logic          ext_ack;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   mxi_memport #(.AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_val(bus_val),
      .mar_load(mar_load), .mbr_load(mbr_load), .mem_op(mem_op),
      .mar_q(mar_q), .mbr_q(mbr_q), .step_hold(step_hold), .op_err(op_err),
      .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      bus_val = '0; mar_load = 0; mbr_load = 0; mem_op = 2'b00;
      ext_ack = 0; ext_rdata = '0;
   endtask

   task automatic t_reset();
      chk(ext_req == 0,   "R1 req",  ext_req, 0);
      chk(step_hold == 0, "R1 hold", step_hold, 0);
      chk(op_err == 0,    "R1 err",  op_err, 0);
      chk(mar_q == 0,     "R1 mar",  mar_q, 0);
      chk(mbr_q == 0,     "R1 mbr",  mbr_q, 0);
   endtask

   task automatic t_read();
      bus_val = 16'h0012; mar_load = 1; mem_op = 2'b01;
      cyc();
      idle();
      chk(mar_q == 16'h0012,    "R2 mar load", mar_q, 16'h0012);
      chk(ext_req && !ext_we,   "R3 read req", {ext_req, ext_we}, 2'b10);
      chk(ext_addr == 16'h0012, "R3 read addr", ext_addr, 16'h0012);
      mem_op = 2'b11;
      #0.5;
      chk(step_hold == 1, "R6 hold during wait", step_hold, 1);
      cyc();
      chk(ext_req && ext_addr == 16'h0012, "R5 held", ext_addr, 16'h0012);
      ext_ack = 1; ext_rdata = 16'h00A5;
      #0.5;
      chk(step_hold == 0, "R6 release on ack", step_hold, 0);
      cyc();
      idle();
      chk(mbr_q == 16'h00A5, "R7 read capture", mbr_q, 16'h00A5);
      chk(ext_req == 0,      "R5 req drop", ext_req, 0);
   endtask

   task automatic t_write();
      bus_val = 16'h0034; mar_load = 1;
      cyc();
      idle();
      bus_val = 16'h0077; mbr_load = 1; mem_op = 2'b10;
      cyc();
      idle();
      chk(mbr_q == 16'h0077, "R2 mbr load", mbr_q, 16'h0077);
      chk(ext_req && ext_we, "R4 write req", {ext_req, ext_we}, 2'b11);
      chk(ext_addr == 16'h0034,  "R4 write addr", ext_addr, 16'h0034);
      chk(ext_wdata == 16'h0077, "R4 write data", ext_wdata, 16'h0077);
      ext_ack = 1; ext_rdata = 16'h00FF;
      cyc();
      idle();
      chk(mbr_q == 16'h0077, "R7 write keeps mbr", mbr_q, 16'h0077);
      chk(ext_req == 0, "R5 write req drop", ext_req, 0);
   endtask

   task automatic t_idle_wait();
      mem_op = 2'b11;
      #0.5;
      chk(step_hold == 0, "R8 idle wait", step_hold, 0);
      cyc();
      idle();
      chk(ext_req == 0, "R8 no request", ext_req, 0);
   endtask

   task automatic t_busy_err();
      bus_val = 16'h0005; mar_load = 1; mem_op = 2'b01;
      cyc();
      idle();
      bus_val = 16'h0009; mar_load = 1; mem_op = 2'b10;
      cyc();
      idle();
      chk(op_err == 1, "R9 err set", op_err, 1);
      chk(ext_addr == 16'h0005 && !ext_we, "R9 request kept",
          {ext_we, ext_addr}, {1'b0, 16'h0005});
      ext_ack = 1; ext_rdata = 16'h0042;
      cyc();
      idle();
      cyc();
      chk(op_err == 1, "R9 err sticky", op_err, 1);
   endtask

   task automatic t_collide();
      bus_val = 16'h0020; mar_load = 1; mem_op = 2'b01;
      cyc();
      idle();
      ext_ack = 1; ext_rdata = 16'h003C; bus_val = 16'h0099; mbr_load = 1;
      cyc();
      idle();
      chk(mbr_q == 16'h003C, "R10 read wins", mbr_q, 16'h003C);
   endtask

   initial begin
      idle();
      rst_n = 0;
      cyc(); cyc();
      rst_n = 1;
      cyc();
      t_reset();
      t_read();
      t_write();
      t_idle_wait();
      t_busy_err();
      t_collide();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule